// File: doc/BRIEF.md
# Seven-Stage Pipeline Hazard Unit

This block decides, every cycle, how the front of an in-order pipeline with stages F1, F2, DE, EX, M1, M2 and WB should move. Instruction fetch and data access each take two stages. Load data therefore exists only at the end of M2, while an ALU result is ready as soon as the instruction reaches M1. The unit looks at the instruction waiting in DE and at the producers in EX, M1, M2 and WB, and picks one of three front modes. FRONT_RUN lets everything advance. FRONT_HOLD freezes F1, F2 and DE and sends a bubble into EX. FRONT_FLUSH clears F1, F2 and DE after a taken branch in EX. The mode is chosen afresh every cycle. FRONT_FLUSH beats FRONT_HOLD, FRONT_HOLD beats FRONT_RUN, and any mode can follow any other.

For the instruction in EX, the unit also chooses where each operand comes from: the register-file value or one of three forwarding paths (M1, M2, WB). The register-file operand is read as the instruction enters EX, so a write made in WB is visible to it from the next cycle on. A mode input turns forwarding off. In that mode every operand comes from the register file, and a dependent instruction waits in DE until its producer has left WB. The unit is purely combinational from stage contents to controls. The clock and reset serve only its checking properties.

Instruction classes are encoded on two bits: 0 for none (bubble or branch), 1 for ALU, 2 for load and 3 for store. Only valid classes 1 and 2 write a register. All registers, register 0 included, are ordinary.

Top module: `pipe7_hazard_ctl`

## Requirements
- R1: With no valid instruction in DE and no taken branch, front_hold, front_flush and ex_bubble are all 0.
- R2: With forwarding on, front_hold is 1 exactly when DE is valid, no branch is taken, and a used DE source equals the destination of a valid load (class 2) in EX or M1.
- R3: With forwarding on, a load followed at once by an instruction that reads its result costs exactly two hold cycles, on either source operand. An ALU producer followed at once by its consumer costs none.
- R4: With forwarding off, front_hold is 1 when DE is valid, no branch is taken, and a used DE source equals the destination of any valid writer in EX, M1, M2 or WB. Both operand selects are then 0.
- R5: With forwarding on, an EX operand select is 1 (M1) when the matching youngest writer is an ALU instruction in M1, 2 when it sits in M2, and 3 when it sits in WB. The select is 0 (register file) when there is no match or the operand is unused. A younger match always shadows an older one.
- R6: When br_taken is 1, front_flush and ex_bubble are 1 and front_hold is 0, whatever hazards exist.
- R7: ex_bubble is 1 whenever front_hold or front_flush is 1, and 0 otherwise.
- R8: Stores (class 3) and class-0 entries never act as producers, even when their destination field matches. Register 0 is hazard-checked like any other register.
- R9: With forwarding off, an instruction that reads the result of the instruction just ahead of it is held for exactly four cycles, whether that producer is an ALU or a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the checking properties |
| rst_n | input | 1 | Active-low reset, disables the properties |
| fwd_en | input | 1 | 1 = forwarding on, 0 = resolve only by holding |
| br_taken | input | 1 | Branch in EX is taken |
| de_valid | input | 1 | DE holds a valid instruction |
| de_use_a | input | 1 | DE reads source A |
| de_src_a | input | REG_W | DE source A register |
| de_use_b | input | 1 | DE reads source B |
| de_src_b | input | REG_W | DE source B register |
| ex_valid | input | 1 | EX holds a valid instruction |
| ex_class | input | 2 | EX class code |
| ex_dst | input | REG_W | EX destination register |
| ex_use_a | input | 1 | EX reads source A |
| ex_src_a | input | REG_W | EX source A register |
| ex_use_b | input | 1 | EX reads source B |
| ex_src_b | input | REG_W | EX source B register |
| m1_valid | input | 1 | M1 holds a valid instruction |
| m1_class | input | 2 | M1 class code |
| m1_dst | input | REG_W | M1 destination register |
| m2_valid | input | 1 | M2 holds a valid instruction |
| m2_class | input | 2 | M2 class code |
| m2_dst | input | REG_W | M2 destination register |
| wb_valid | input | 1 | WB holds a valid instruction |
| wb_class | input | 2 | WB class code |
| wb_dst | input | REG_W | WB destination register |
| front_hold | output | 1 | Freeze F1, F2 and DE |
| front_flush | output | 1 | Clear F1, F2 and DE |
| ex_bubble | output | 1 | Load a bubble into EX |
| ex_sel_a | output | 2 | EX operand A source: 0 RF, 1 M1, 2 M2, 3 WB |
| ex_sel_b | output | 2 | EX operand B source: 0 RF, 1 M1, 2 M2, 3 WB |

## Verification
The bench runs its own model of the pipeline and steers it with the controls the model expects, not with the design's outputs. A wrong mode decision therefore shows up in the same cycle as a front_hold, front_flush or ex_bubble mismatch. It then goes on to change which instructions reach EX, and that in turn shows up as select mismatches a few cycles later. A wrong priority among the forwarding stages appears on ex_sel_a or ex_sel_b in the cycle the consumer sits in EX. Directed pairs count hold cycles to pin down the two-cycle load penalty and the four-cycle penalty with forwarding off.

// File: rtl/p7h_pkg.sv
package p7h_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ALU   = 2'd1,
        CLS_LOAD  = 2'd2,
        CLS_STORE = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        SEL_RF = 2'd0,
        SEL_M1 = 2'd1,
        SEL_M2 = 2'd2,
        SEL_WB = 2'd3
    } opnd_sel_e;

    typedef enum logic [1:0] {
        FRONT_RUN   = 2'd0,
        FRONT_HOLD  = 2'd1,
        FRONT_FLUSH = 2'd2
    } front_mode_e;

    // producer stage indices, youngest first
    localparam int STG_EX = 0;
    localparam int STG_M1 = 1;
    localparam int STG_M2 = 2;
    localparam int STG_WB = 3;
    localparam int N_PROD = 4;

    function automatic logic cls_writes(input logic v, input logic [1:0] c);
        return v && (c == CLS_ALU || c == CLS_LOAD);
    endfunction

endpackage

// File: rtl/p7h_src_match.sv
module p7h_src_match #(
    parameter int REG_W = 3,
    parameter int N     = 4
) (
    input  logic                      rd_en_i,
    input  logic [REG_W-1:0]          src_i,
    input  logic [N-1:0]              wr_i,
    input  logic [N-1:0][REG_W-1:0]   dst_i,
    output logic [N-1:0]              hit_o
);

    for (genvar k = 0; k < N; k++) begin : g_stage
        assign hit_o[k] = rd_en_i && wr_i[k] && (dst_i[k] == src_i);
    end

endmodule

// File: rtl/p7h_opnd_pick.sv
module p7h_opnd_pick
    import p7h_pkg::*;
#(
    parameter int REG_W = 3,
    parameter int N_SRC = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fwd_en,
    input  logic                         rd_en_i,
    input  logic [REG_W-1:0]             src_i,
    input  logic [N_SRC-1:0]             wr_i,
    input  logic [N_SRC-1:0]             ld_i,
    input  logic [N_SRC-1:0][REG_W-1:0]  dst_i,
    output logic [1:0]                   sel_o
);

    logic [N_SRC-1:0] hit;
    opnd_sel_e        sel_e;

    p7h_src_match #(.REG_W(REG_W), .N(N_SRC)) u_match (
        .rd_en_i (rd_en_i),
        .src_i   (src_i),
        .wr_i    (wr_i),
        .dst_i   (dst_i),
        .hit_o   (hit)
    );

    // index 0 is M1, 1 is M2, 2 is WB; the youngest match wins
    always_comb begin
        sel_e = SEL_RF;
        if (fwd_en) begin
            if (hit[0])      sel_e = ld_i[0] ? SEL_RF : SEL_M1;
            else if (hit[1]) sel_e = SEL_M2;
            else if (hit[2]) sel_e = SEL_WB;
        end
    end

    assign sel_o = sel_e;

    assert_rf_only_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_en |-> sel_o == SEL_RF);

    assert_m1_alu_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o == SEL_M1 |-> (wr_i[0] && !ld_i[0] && rd_en_i));

    assert_unused_reads_rf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |-> sel_o == SEL_RF);

endmodule

// File: rtl/pipe7_hazard_ctl.sv
module pipe7_hazard_ctl
    import p7h_pkg::*;
#(
    parameter int REG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_en,
    input  logic             br_taken,
    input  logic             de_valid,
    input  logic             de_use_a,
    input  logic [REG_W-1:0] de_src_a,
    input  logic             de_use_b,
    input  logic [REG_W-1:0] de_src_b,
    input  logic             ex_valid,
    input  logic [1:0]       ex_class,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_use_a,
    input  logic [REG_W-1:0] ex_src_a,
    input  logic             ex_use_b,
    input  logic [REG_W-1:0] ex_src_b,
    input  logic             m1_valid,
    input  logic [1:0]       m1_class,
    input  logic [REG_W-1:0] m1_dst,
    input  logic             m2_valid,
    input  logic [1:0]       m2_class,
    input  logic [REG_W-1:0] m2_dst,
    input  logic             wb_valid,
    input  logic [1:0]       wb_class,
    input  logic [REG_W-1:0] wb_dst,
    output logic             front_hold,
    output logic             front_flush,
    output logic             ex_bubble,
    output logic [1:0]       ex_sel_a,
    output logic [1:0]       ex_sel_b
);

    localparam int N_OPND = 2;
    // stages whose load result is not yet available to forward
    localparam logic [N_PROD-1:0] LD_WAIT_MASK = N_PROD'((1 << STG_EX) | (1 << STG_M1));

    logic [N_PROD-1:0]             prod_wr;
    logic [N_PROD-1:0]             prod_ld;
    logic [N_PROD-1:0][REG_W-1:0]  prod_dst;

    logic [N_OPND-1:0]             de_rd_v;
    logic [N_OPND-1:0][REG_W-1:0]  de_src_v;
    logic [N_OPND-1:0]             ex_rd_v;
    logic [N_OPND-1:0][REG_W-1:0]  ex_src_v;
    logic [N_OPND-1:0][1:0]        ex_sel_v;
    logic [N_OPND-1:0][N_PROD-1:0] de_hit;

    logic        hit_any;
    logic        hit_ld;
    logic        need_hold;
    front_mode_e mode;

    always_comb begin
        prod_wr[STG_EX]  = cls_writes(ex_valid, ex_class);
        prod_wr[STG_M1]  = cls_writes(m1_valid, m1_class);
        prod_wr[STG_M2]  = cls_writes(m2_valid, m2_class);
        prod_wr[STG_WB]  = cls_writes(wb_valid, wb_class);
        prod_ld[STG_EX]  = ex_valid && (ex_class == CLS_LOAD);
        prod_ld[STG_M1]  = m1_valid && (m1_class == CLS_LOAD);
        prod_ld[STG_M2]  = m2_valid && (m2_class == CLS_LOAD);
        prod_ld[STG_WB]  = wb_valid && (wb_class == CLS_LOAD);
        prod_dst[STG_EX] = ex_dst;
        prod_dst[STG_M1] = m1_dst;
        prod_dst[STG_M2] = m2_dst;
        prod_dst[STG_WB] = wb_dst;
    end

    assign de_rd_v  = {de_use_b, de_use_a};
    assign de_src_v = {de_src_b, de_src_a};
    assign ex_rd_v  = {ex_use_b, ex_use_a};
    assign ex_src_v = {ex_src_b, ex_src_a};

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        p7h_src_match #(.REG_W(REG_W), .N(N_PROD)) u_de_match (
            .rd_en_i (de_rd_v[g]),
            .src_i   (de_src_v[g]),
            .wr_i    (prod_wr),
            .dst_i   (prod_dst),
            .hit_o   (de_hit[g])
        );

        p7h_opnd_pick #(.REG_W(REG_W), .N_SRC(N_PROD-1)) u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .fwd_en  (fwd_en),
            .rd_en_i (ex_rd_v[g]),
            .src_i   (ex_src_v[g]),
            .wr_i    (prod_wr[N_PROD-1:1]),
            .ld_i    (prod_ld[N_PROD-1:1]),
            .dst_i   (prod_dst[N_PROD-1:1]),
            .sel_o   (ex_sel_v[g])
        );
    end

    assign ex_sel_a = ex_sel_v[0];
    assign ex_sel_b = ex_sel_v[1];

    // mode selection: flush beats hold, hold beats run
    always_comb begin
        hit_any   = |(de_hit[0] | de_hit[1]);
        hit_ld    = |((de_hit[0] | de_hit[1]) & prod_ld & LD_WAIT_MASK);
        need_hold = de_valid && (fwd_en ? hit_ld : hit_any);
        if (br_taken)       mode = FRONT_FLUSH;
        else if (need_hold) mode = FRONT_HOLD;
        else                mode = FRONT_RUN;
    end

    // outputs per mode
    always_comb begin
        front_hold  = 1'b0;
        front_flush = 1'b0;
        ex_bubble   = 1'b0;
        unique case (mode)
            FRONT_RUN: begin
            end
            FRONT_HOLD: begin
                front_hold = 1'b1;
                ex_bubble  = 1'b1;
            end
            FRONT_FLUSH: begin
                front_flush = 1'b1;
                ex_bubble   = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assert_flush_beats_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (front_flush && ex_bubble && !front_hold));

    assert_hold_has_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        front_hold |-> ex_bubble);

    assert_idle_is_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!de_valid && !br_taken) |-> (!front_hold && !front_flush && !ex_bubble));

    assert_hold_needs_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        front_hold |-> (|prod_wr));

    assert_fwd_hold_only_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (front_hold && fwd_en) |-> (|(prod_ld & LD_WAIT_MASK)));

endmodule

// File: tb/pipe7_hazard_ctl_tb_top.sv
`timescale 1ns/1ps
module pipe7_hazard_ctl_tb_top;
    import p7h_pkg::*;

    localparam int REG_W = 3;

    typedef struct packed {
        logic             v;
        logic             br;
        logic [1:0]       cls;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] a;
        logic [REG_W-1:0] b;
        logic             ua;
        logic             ub;
    } ins_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic fwd_en = 1'b1, br_taken = 1'b0;
    logic de_valid = 0, de_use_a = 0, de_use_b = 0;
    logic [REG_W-1:0] de_src_a = 0, de_src_b = 0;
    logic ex_valid = 0, ex_use_a = 0, ex_use_b = 0;
    logic [1:0] ex_class = 0, m1_class = 0, m2_class = 0, wb_class = 0;
    logic [REG_W-1:0] ex_dst = 0, ex_src_a = 0, ex_src_b = 0;
    logic m1_valid = 0, m2_valid = 0, wb_valid = 0;
    logic [REG_W-1:0] m1_dst = 0, m2_dst = 0, wb_dst = 0;
    logic front_hold, front_flush, ex_bubble;
    logic [1:0] ex_sel_a, ex_sel_b;

    pipe7_hazard_ctl #(.REG_W(REG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .br_taken(br_taken),
        .de_valid(de_valid), .de_use_a(de_use_a), .de_src_a(de_src_a),
        .de_use_b(de_use_b), .de_src_b(de_src_b),
        .ex_valid(ex_valid), .ex_class(ex_class), .ex_dst(ex_dst),
        .ex_use_a(ex_use_a), .ex_src_a(ex_src_a), .ex_use_b(ex_use_b), .ex_src_b(ex_src_b),
        .m1_valid(m1_valid), .m1_class(m1_class), .m1_dst(m1_dst),
        .m2_valid(m2_valid), .m2_class(m2_class), .m2_dst(m2_dst),
        .wb_valid(wb_valid), .wb_class(wb_class), .wb_dst(wb_dst),
        .front_hold(front_hold), .front_flush(front_flush), .ex_bubble(ex_bubble),
        .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b)
    );

    // model stages: 0 F1, 1 F2, 2 DE, 3 EX, 4 M1, 5 M2, 6 WB
    ins_t st[7];
    ins_t feed_q[$];
    bit   quiet = 0;
    int   checks = 0, errors = 0;
    bit   done = 0;
    bit   e_hold, e_flush, e_bub;
    int   e_sel_a, e_sel_b;

    function automatic logic [REG_W-1:0] rand_reg();
        return ($urandom_range(0, 7) == 0) ? REG_W'($urandom_range(0, 7)) : REG_W'($urandom_range(0, 3));
    endfunction

    function automatic ins_t rand_ins();
        ins_t i = '0;
        int   r = $urandom_range(0, 9);
        i.v = 1'b1; i.dst = rand_reg(); i.a = rand_reg(); i.b = rand_reg();
        i.ua = 1'b1; i.ub = ($urandom_range(0, 1) == 1);
        if (r <= 3)      i.cls = 2'd1;
        else if (r <= 5) i.cls = 2'd2;
        else if (r <= 7) i.cls = 2'd3;
        else if (r == 8) begin i.cls = 2'd0; i.br = 1'b1; end
        else             i = '0;
        return i;
    endfunction

    function automatic ins_t mk(int cls, int dst, int ua, int a, int ub, int b);
        ins_t i = '0;
        i.v = 1'b1; i.cls = 2'(cls); i.dst = REG_W'(dst);
        i.ua = (ua != 0); i.a = REG_W'(a); i.ub = (ub != 0); i.b = REG_W'(b);
        return i;
    endfunction

    function automatic bit writes(ins_t p);
        return p.v && (p.cls == 2'd1 || p.cls == 2'd2);
    endfunction

    function automatic bit hit(ins_t p, bit u, logic [REG_W-1:0] r);
        return u && writes(p) && (p.dst == r);
    endfunction

    function automatic int ref_sel(bit u, logic [REG_W-1:0] r);
        if (!fwd_en || !u) return 0;
        if (hit(st[4], 1'b1, r)) return (st[4].cls == 2'd1) ? 1 : 0;
        if (hit(st[5], 1'b1, r)) return 2;
        if (hit(st[6], 1'b1, r)) return 3;
        return 0;
    endfunction

    task automatic compute_ref();
        bit hraw = 0;
        for (int k = 3; k <= 6; k++) begin
            bit ha = hit(st[k], st[2].ua, st[2].a) || hit(st[k], st[2].ub, st[2].b);
            if (fwd_en) begin
                if (ha && st[k].cls == 2'd2 && k <= 4) hraw = 1;
            end else if (ha) hraw = 1;
        end
        e_flush = br_taken;
        e_hold  = st[2].v && hraw && !br_taken;
        e_bub   = e_hold || e_flush;
        e_sel_a = ref_sel(st[3].ua, st[3].a);
        e_sel_b = ref_sel(st[3].ub, st[3].b);
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic ins_t next_ins();
        if (feed_q.size() > 0) return feed_q.pop_front();
        if (quiet) return '0;
        return rand_ins();
    endfunction

    task automatic drive();
        de_valid = st[2].v; de_use_a = st[2].ua; de_src_a = st[2].a;
        de_use_b = st[2].ub; de_src_b = st[2].b;
        ex_valid = st[3].v; ex_class = st[3].cls; ex_dst = st[3].dst;
        ex_use_a = st[3].ua; ex_src_a = st[3].a; ex_use_b = st[3].ub; ex_src_b = st[3].b;
        m1_valid = st[4].v; m1_class = st[4].cls; m1_dst = st[4].dst;
        m2_valid = st[5].v; m2_class = st[5].cls; m2_dst = st[5].dst;
        wb_valid = st[6].v; wb_class = st[6].cls; wb_dst = st[6].dst;
        br_taken = st[3].v && st[3].br && ($urandom_range(0, 1) == 1);
    endtask

    task automatic advance();
        st[6] = st[5]; st[5] = st[4]; st[4] = st[3];
        if (e_flush) begin
            st[3] = '0; st[2] = '0; st[1] = '0; st[0] = next_ins();
        end else if (e_hold) begin
            st[3] = '0;
        end else begin
            st[3] = st[2]; st[2] = st[1]; st[1] = st[0]; st[0] = next_ins();
        end
    endtask

    // one cycle: drive, compare away from the edge, advance by reference controls
    task automatic step(output int got_hold);
        drive();
        @(negedge clk);
        compute_ref();
        check(br_taken ? "R6" : (fwd_en ? "R2" : "R4"), "front_hold", int'(front_hold), int'(e_hold));
        check("R6", "front_flush", int'(front_flush), int'(e_flush));
        check("R7", "ex_bubble", int'(ex_bubble), int'(e_bub));
        check(fwd_en ? "R5" : "R4", "ex_sel_a", int'(ex_sel_a), e_sel_a);
        check(fwd_en ? "R5" : "R4", "ex_sel_b", int'(ex_sel_b), e_sel_b);
        got_hold = int'(front_hold);
        @(posedge clk);
        #0.5;
        advance();
    endtask

    task automatic drain();
        int h;
        quiet = 1;
        while (feed_q.size() > 0) step(h);
        repeat (8) step(h);
    endtask

    task automatic run_pair(ins_t p, ins_t c, int exp, string req, string what);
        int h, total = 0;
        drain();
        feed_q.push_back(p);
        feed_q.push_back(c);
        while (feed_q.size() > 0) begin step(h); total += h; end
        repeat (10) begin step(h); total += h; end
        check(req, what, total, exp);
        quiet = 0;
    endtask

    initial begin
        int h;
        for (int k = 0; k < 7; k++) st[k] = '0;
        drive();
        repeat (4) @(posedge clk);
        #0.5 rst_n = 1'b1;
        @(negedge clk);
        // R1: empty pipeline after reset
        check("R1", "front_hold idle", int'(front_hold), 0);
        check("R1", "front_flush idle", int'(front_flush), 0);
        check("R1", "ex_bubble idle", int'(ex_bubble), 0);
        check("R1", "ex_sel_a idle", int'(ex_sel_a), 0);
        @(posedge clk);
        #0.5;

        fwd_en = 1'b1;
        repeat (3000) step(h);
        run_pair(mk(2, 1, 1, 2, 0, 0), mk(1, 3, 1, 1, 1, 4), 2, "R3", "load-use holds on A");
        run_pair(mk(2, 5, 1, 2, 0, 0), mk(1, 3, 1, 6, 1, 5), 2, "R3", "load-use holds on B");
        run_pair(mk(1, 1, 1, 2, 0, 0), mk(1, 3, 1, 1, 1, 1), 0, "R3", "alu-use holds");
        run_pair(mk(2, 0, 1, 2, 0, 0), mk(1, 3, 1, 0, 0, 0), 2, "R8", "register 0 load-use holds");

        fwd_en = 1'b0;
        repeat (3000) step(h);
        run_pair(mk(1, 1, 1, 2, 0, 0), mk(1, 3, 1, 1, 0, 0), 4, "R9", "alu-use holds no fwd");
        run_pair(mk(2, 2, 1, 4, 0, 0), mk(3, 0, 1, 5, 1, 2), 4, "R9", "load-use holds no fwd");
        run_pair(mk(3, 1, 1, 2, 1, 3), mk(1, 3, 1, 1, 1, 1), 0, "R8", "store as producer holds");
        run_pair(mk(0, 1, 0, 0, 0, 0), mk(1, 3, 1, 1, 0, 0), 0, "R8", "class-0 as producer holds");

        for (int blk = 0; blk < 60; blk++) begin
            fwd_en = ($urandom_range(0, 1) == 1);
            repeat (50) step(h);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule